// File: doc/BRIEF.md
# UART Interrupt Event and Status Unit

This unit gathers the event strobes of a serial port and turns them into one interrupt line. The receive, transmit and host-write FIFOs report what they do as single-cycle strobes, each with the occupancy count the FIFO had in that cycle. The receiver reports framing and parity errors. A protocol-mode read error arrives as a strobe of its own. From these inputs the unit works out overflow and misuse conditions, detects almost-full and almost-empty crossings against two programmable thresholds, and records every event in a sticky status register. Software clears that register by writing ones.

A mask register decides which recorded events may raise the interrupt. A masked bit still records its event. The interrupt output is a register: it follows the unmasked status one clock after the change. A small register port gives read and write access to the status, the mask and the two thresholds. The FIFOs, the serial shifter, the baud generator and any bus decoding sit outside this unit.

Top module: `uart_evt_irq`

## Requirements
- R1: A framing-error strobe sets status bit 2. A parity-error strobe sets bit 3. A protocol-mode read-error strobe sets bit 10. A bit that has been set stays set until software clears it.
- R2: Writing to the status register (`reg_addr_i` = 0) clears each status bit whose write-data bit is 1. Write-data bits of 0 leave the status unchanged.
- R3: When an event sets a status bit in the same cycle as a write that clears that bit, the bit ends up set.
- R4: A received byte (`rx_byte_vld_i`) arriving while the receive count is below 256 is a push and sets bit 8. A byte arriving while the count is 256 sets bit 4 (overflow) and sets neither bit 8 nor bit 5.
- R5: A receive push sets bit 5 when the receive count in that cycle is greater than or equal to the almost-full threshold.
- R6: A transmit pop (`tx_pop_i`) with a nonzero transmit count sets bit 7. A pop strobe with a count of 0 sets no bit.
- R7: A transmit pop with a nonzero count sets bit 11 when the count minus one (the entries left after the pop) is less than or equal to the almost-empty threshold. With a threshold of 0, only a pop from a count of 1 sets it.
- R8: A host write (`wr_push_i`) while the write-FIFO count is 4 sets bit 1. A write-FIFO pop with a nonzero count sets bit 9, and a pop with a count of 0 sets nothing.
- R9: A receive-data read (`rx_data_rd_i`) while the receive count is 0 sets bit 0. A read at any other count sets nothing.
- R10: `irq_o` is 1 exactly when some status bit is 1 and its mask bit is 0. It changes on the clock edge that updates the status or the mask. A mask bit blocks only the interrupt, never the recording in the status register.
- R11: Address 1 is the mask, address 2 the 9-bit almost-full threshold and address 3 the 9-bit almost-empty threshold. Reads are zero-extended to 64 bits. Status and mask bit 6 and bits 12 to 63 always read 0, and writes to them are ignored. Threshold bits above bit 8 are also ignored.
- R12: After reset the status is 0, the mask is 0xFBF (every implemented bit masked), the almost-full threshold is 256, the almost-empty threshold is 0 and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_byte_vld_i | input | 1 | Received byte offered to the receive FIFO |
| rx_level_i | input | 9 | Receive FIFO occupancy, 0 to 256 |
| rx_data_rd_i | input | 1 | Receive data read by the host |
| rx_proto_err_i | input | 1 | Protocol-mode receive read error strobe |
| frame_err_i | input | 1 | Missing stop bit on the current byte |
| parity_err_i | input | 1 | Parity mismatch on the current byte |
| tx_pop_i | input | 1 | Transmit FIFO pop strobe |
| tx_level_i | input | 9 | Transmit FIFO occupancy, 0 to 256 |
| wr_push_i | input | 1 | Host write into the write FIFO |
| wr_pop_i | input | 1 | Write FIFO pop strobe |
| wr_level_i | input | 3 | Write FIFO occupancy, 0 to 4 |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 2 | Register select: 0 status, 1 mask, 2 almost-full, 3 almost-empty |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Register read data for `reg_addr_i` |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The receive and transmit counts are swept over every value from 0 to 256 under five threshold settings each. These sweeps separate "greater than or equal" from "greater than", the count after a pop from the count before it, and the full and empty limits from the ordinary counts. The mask is swept over all 4096 values while every implemented status bit is set, which shows that each bit alone keeps the interrupt up and that bit 6 never sticks. Directed sequences clear one bit at a time and collide an event with a clear of the same bit. Further sequences time the rising and falling interrupt edge against the clock edge that changes the status.

// File: rtl/uart_evt_pkg.sv
package uart_evt_pkg;

    localparam int EVT_W = 12;

    // Bit positions inside the status and mask words.
    localparam int EV_RD_EMPTY  = 0;
    localparam int EV_WR_FULL   = 1;
    localparam int EV_FRAME     = 2;
    localparam int EV_PARITY    = 3;
    localparam int EV_RX_OVF    = 4;
    localparam int EV_RX_AFULL  = 5;
    localparam int EV_RSVD      = 6;
    localparam int EV_TX_POP    = 7;
    localparam int EV_RX_PUSH   = 8;
    localparam int EV_WR_POP    = 9;
    localparam int EV_PROTO_RD  = 10;
    localparam int EV_TX_AEMPTY = 11;

    typedef logic [EVT_W-1:0] evt_vec_t;

    // Bits that hold state; the reserved hole stays zero.
    localparam evt_vec_t EVT_IMPL = ~(EVT_W'(1) << EV_RSVD);

    typedef enum logic [1:0] {
        CSR_STATUS = 2'd0,
        CSR_MASK   = 2'd1,
        CSR_HI_THR = 2'd2,
        CSR_LO_THR = 2'd3
    } csr_sel_e;

    typedef enum logic {
        CMP_AT_OR_ABOVE = 1'b0,
        CMP_AT_OR_BELOW = 1'b1
    } thr_cmp_e;

endpackage

// File: rtl/uart_evt_thresh.sv
// Qualifies a FIFO operation against its occupancy and a threshold.
// The comparison runs only when the operation actually happens.
module uart_evt_thresh
    import uart_evt_pkg::*;
#(
    parameter int       LVL_W = 9,
    parameter int       DEPTH = 256,
    parameter thr_cmp_e MODE  = CMP_AT_OR_ABOVE
) (
    input  logic             stb_i,
    input  logic [LVL_W-1:0] level_i,
    input  logic [LVL_W-1:0] thr_i,
    output logic             op_o,
    output logic             cross_o
);

    localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);
    localparam logic [LVL_W-1:0] LVL_ONE  = LVL_W'(1);

    generate
        if (MODE == CMP_AT_OR_ABOVE) begin : g_push
            // Push side: refused when full, crossing judged on count before write.
            logic is_full;
            always_comb begin
                is_full = (level_i >= LVL_FULL);
                op_o    = stb_i && !is_full;
                cross_o = op_o && (level_i >= thr_i);
            end
        end else begin : g_pop
            // Pop side: no-op when empty, crossing judged on entries left.
            logic             is_empty;
            logic [LVL_W-1:0] remain;
            always_comb begin
                is_empty = (level_i == '0);
                remain   = level_i - LVL_ONE;
                op_o     = stb_i && !is_empty;
                cross_o  = op_o && (remain <= thr_i);
            end
        end
    endgenerate

endmodule

// File: rtl/uart_evt_collect.sv
// Maps FIFO strobes, counts and receiver errors onto the event vector.
module uart_evt_collect
    import uart_evt_pkg::*;
#(
    parameter int LVL_W    = 9,
    parameter int RX_DEPTH = 256,
    parameter int TX_DEPTH = 256,
    parameter int WR_LVL_W = 3,
    parameter int WR_DEPTH = 4
) (
    input  logic                rx_byte_vld_i,
    input  logic [LVL_W-1:0]    rx_level_i,
    input  logic                rx_data_rd_i,
    input  logic                rx_proto_err_i,
    input  logic                frame_err_i,
    input  logic                parity_err_i,
    input  logic                tx_pop_i,
    input  logic [LVL_W-1:0]    tx_level_i,
    input  logic                wr_push_i,
    input  logic                wr_pop_i,
    input  logic [WR_LVL_W-1:0] wr_level_i,
    input  logic [LVL_W-1:0]    hi_thr_i,
    input  logic [LVL_W-1:0]    lo_thr_i,
    output evt_vec_t            evt_o
);

    localparam logic [LVL_W-1:0]    RX_FULL = LVL_W'(RX_DEPTH);
    localparam logic [WR_LVL_W-1:0] WR_FULL = WR_LVL_W'(WR_DEPTH);

    logic rx_push, rx_hi_cross;
    logic tx_pop,  tx_lo_cross;

    uart_evt_thresh #(
        .LVL_W (LVL_W),
        .DEPTH (RX_DEPTH),
        .MODE  (CMP_AT_OR_ABOVE)
    ) u_rx_thr (
        .stb_i   (rx_byte_vld_i),
        .level_i (rx_level_i),
        .thr_i   (hi_thr_i),
        .op_o    (rx_push),
        .cross_o (rx_hi_cross)
    );

    uart_evt_thresh #(
        .LVL_W (LVL_W),
        .DEPTH (TX_DEPTH),
        .MODE  (CMP_AT_OR_BELOW)
    ) u_tx_thr (
        .stb_i   (tx_pop_i),
        .level_i (tx_level_i),
        .thr_i   (lo_thr_i),
        .op_o    (tx_pop),
        .cross_o (tx_lo_cross)
    );

    always_comb begin
        evt_o               = '0;
        evt_o[EV_RD_EMPTY]  = rx_data_rd_i && (rx_level_i == '0);
        evt_o[EV_WR_FULL]   = wr_push_i && (wr_level_i >= WR_FULL);
        evt_o[EV_FRAME]     = frame_err_i;
        evt_o[EV_PARITY]    = parity_err_i;
        evt_o[EV_RX_OVF]    = rx_byte_vld_i && (rx_level_i >= RX_FULL);
        evt_o[EV_RX_AFULL]  = rx_hi_cross;
        evt_o[EV_TX_POP]    = tx_pop;
        evt_o[EV_RX_PUSH]   = rx_push;
        evt_o[EV_WR_POP]    = wr_pop_i && (wr_level_i != '0);
        evt_o[EV_PROTO_RD]  = rx_proto_err_i;
        evt_o[EV_TX_AEMPTY] = tx_lo_cross;
    end

endmodule

// File: rtl/uart_evt_csr.sv
// Sticky status with write-one-to-clear, mask, thresholds and the
// registered interrupt; two-process style.
module uart_evt_csr
    import uart_evt_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int LVL_W    = 9,
    parameter int RX_DEPTH = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  evt_vec_t          evt_i,
    input  logic              reg_we_i,
    input  logic [1:0]        reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output evt_vec_t          status_o,
    output evt_vec_t          mask_o,
    output logic [LVL_W-1:0]  hi_thr_o,
    output logic [LVL_W-1:0]  lo_thr_o,
    output logic              irq_o
);

    typedef struct packed {
        evt_vec_t         status;
        evt_vec_t         mask;
        logic [LVL_W-1:0] hi_thr;
        logic [LVL_W-1:0] lo_thr;
        logic             irq;
    } csr_state_t;

    localparam csr_state_t ST_RST = '{
        status : '0,
        mask   : EVT_IMPL,
        hi_thr : LVL_W'(RX_DEPTH),
        lo_thr : '0,
        irq    : 1'b0
    };

    csr_state_t st_d, st_q;
    csr_sel_e   sel;
    evt_vec_t   wr_bits;

    always_comb begin
        sel     = csr_sel_e'(reg_addr_i);
        wr_bits = reg_wdata_i[EVT_W-1:0] & EVT_IMPL;
        st_d    = st_q;

        if (reg_we_i) begin
            case (sel)
                CSR_STATUS: st_d.status = st_q.status & ~wr_bits;
                CSR_MASK:   st_d.mask   = wr_bits;
                CSR_HI_THR: st_d.hi_thr = reg_wdata_i[LVL_W-1:0];
                CSR_LO_THR: st_d.lo_thr = reg_wdata_i[LVL_W-1:0];
                default:    st_d        = st_q;
            endcase
        end

        // Setting is applied after clearing: a colliding event survives.
        st_d.status = (st_d.status | evt_i) & EVT_IMPL;
        st_d.irq    = |(st_d.status & ~st_d.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RST;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        case (sel)
            CSR_STATUS: reg_rdata_o[EVT_W-1:0] = st_q.status;
            CSR_MASK:   reg_rdata_o[EVT_W-1:0] = st_q.mask;
            CSR_HI_THR: reg_rdata_o[LVL_W-1:0] = st_q.hi_thr;
            CSR_LO_THR: reg_rdata_o[LVL_W-1:0] = st_q.lo_thr;
            default:    reg_rdata_o            = '0;
        endcase
    end

    assign status_o = st_q.status;
    assign mask_o   = st_q.mask;
    assign hi_thr_o = st_q.hi_thr;
    assign lo_thr_o = st_q.lo_thr;
    assign irq_o    = st_q.irq;

endmodule

// File: rtl/uart_evt_irq.sv
module uart_evt_irq
    import uart_evt_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int LVL_W    = 9,
    parameter int RX_DEPTH = 256,
    parameter int TX_DEPTH = 256,
    parameter int WR_LVL_W = 3,
    parameter int WR_DEPTH = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_byte_vld_i,
    input  logic [LVL_W-1:0]    rx_level_i,
    input  logic                rx_data_rd_i,
    input  logic                rx_proto_err_i,
    input  logic                frame_err_i,
    input  logic                parity_err_i,
    input  logic                tx_pop_i,
    input  logic [LVL_W-1:0]    tx_level_i,
    input  logic                wr_push_i,
    input  logic                wr_pop_i,
    input  logic [WR_LVL_W-1:0] wr_level_i,
    input  logic                reg_we_i,
    input  logic [1:0]          reg_addr_i,
    input  logic [DATA_W-1:0]   reg_wdata_i,
    output logic [DATA_W-1:0]   reg_rdata_o,
    output logic                irq_o
);

    evt_vec_t         evt;
    evt_vec_t         status_q;
    evt_vec_t         mask_q;
    logic [LVL_W-1:0] hi_thr_q;
    logic [LVL_W-1:0] lo_thr_q;

    uart_evt_collect #(
        .LVL_W    (LVL_W),
        .RX_DEPTH (RX_DEPTH),
        .TX_DEPTH (TX_DEPTH),
        .WR_LVL_W (WR_LVL_W),
        .WR_DEPTH (WR_DEPTH)
    ) u_collect (
        .rx_byte_vld_i  (rx_byte_vld_i),
        .rx_level_i     (rx_level_i),
        .rx_data_rd_i   (rx_data_rd_i),
        .rx_proto_err_i (rx_proto_err_i),
        .frame_err_i    (frame_err_i),
        .parity_err_i   (parity_err_i),
        .tx_pop_i       (tx_pop_i),
        .tx_level_i     (tx_level_i),
        .wr_push_i      (wr_push_i),
        .wr_pop_i       (wr_pop_i),
        .wr_level_i     (wr_level_i),
        .hi_thr_i       (hi_thr_q),
        .lo_thr_i       (lo_thr_q),
        .evt_o          (evt)
    );

    uart_evt_csr #(
        .DATA_W   (DATA_W),
        .LVL_W    (LVL_W),
        .RX_DEPTH (RX_DEPTH)
    ) u_csr (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt),
        .reg_we_i    (reg_we_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .status_o    (status_q),
        .mask_o      (mask_q),
        .hi_thr_o    (hi_thr_q),
        .lo_thr_o    (lo_thr_q),
        .irq_o       (irq_o)
    );

endmodule

// File: rtl/uart_evt_irq_chk.sv
module uart_evt_irq_chk
    import uart_evt_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int LVL_W    = 9,
    parameter int RX_DEPTH = 256
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_err_i,
    input logic              rx_byte_vld_i,
    input logic [LVL_W-1:0]  rx_level_i,
    input logic              reg_we_i,
    input logic [1:0]        reg_addr_i,
    input logic [DATA_W-1:0] reg_wdata_i,
    input evt_vec_t          status_q,
    input evt_vec_t          mask_q,
    input logic              irq_o
);

    logic status_wr;
    assign status_wr = reg_we_i && (reg_addr_i == 2'd0);

    // R1: a framing strobe is recorded on the next edge
    assert_frame_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err_i |=> status_q[EV_FRAME]);

    // R2: a one clears a bit that no event sets again
    assert_w1c_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (status_wr && reg_wdata_i[EV_FRAME] && !frame_err_i) |=> !status_q[EV_FRAME]);

    // R2: an all-zero write loses no status bit
    assert_zero_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (status_wr && (reg_wdata_i[EVT_W-1:0] == '0))
        |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R3: set beats clear on a collision
    assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (status_wr && reg_wdata_i[EV_FRAME] && frame_err_i) |=> status_q[EV_FRAME]);

    // R4: arrival at a full receive FIFO flags overflow
    assert_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_byte_vld_i && (rx_level_i >= LVL_W'(RX_DEPTH))) |=> status_q[EV_RX_OVF]);

    // R10: interrupt tracks unmasked status
    assert_irq_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == |(status_q & ~mask_q));

    // R11: reserved bit never holds a one
    assert_rsvd_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !status_q[EV_RSVD] && !mask_q[EV_RSVD]);

endmodule

bind uart_evt_irq uart_evt_irq_chk #(
    .DATA_W   (DATA_W),
    .LVL_W    (LVL_W),
    .RX_DEPTH (RX_DEPTH)
) u_chk (.*);

// File: tb/uart_evt_irq_bench.sv
module uart_evt_irq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int LVL_W      = 9;
    localparam int DATA_W     = 64;
    localparam int WATCHDOG   = 150000;

    // Bench-side bit positions, taken from the requirements.
    localparam int B_RD_EMPTY = 0;
    localparam int B_WR_FULL  = 1;
    localparam int B_FRAME    = 2;
    localparam int B_PARITY   = 3;
    localparam int B_OVF      = 4;
    localparam int B_AFULL    = 5;
    localparam int B_TX_POP   = 7;
    localparam int B_RX_PUSH  = 8;
    localparam int B_WR_POP   = 9;
    localparam int B_PROTO    = 10;
    localparam int B_AEMPTY   = 11;
    localparam logic [63:0] ALL_IMPL = 64'hFBF;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              rx_byte_vld_i, rx_data_rd_i, rx_proto_err_i;
    logic              frame_err_i, parity_err_i, tx_pop_i;
    logic              wr_push_i, wr_pop_i, reg_we_i;
    logic [LVL_W-1:0]  rx_level_i, tx_level_i;
    logic [2:0]        wr_level_i;
    logic [1:0]        reg_addr_i;
    logic [DATA_W-1:0] reg_wdata_i;
    logic [DATA_W-1:0] reg_rdata_o;
    logic              irq_o;

    int  vectors    = 0;
    int  miscompares = 0;
    bit  done       = 1'b0;

    uart_evt_irq u_uart_evt_irq (
        .clk            (clk),
        .rst_n          (rst_n),
        .rx_byte_vld_i  (rx_byte_vld_i),
        .rx_level_i     (rx_level_i),
        .rx_data_rd_i   (rx_data_rd_i),
        .rx_proto_err_i (rx_proto_err_i),
        .frame_err_i    (frame_err_i),
        .parity_err_i   (parity_err_i),
        .tx_pop_i       (tx_pop_i),
        .tx_level_i     (tx_level_i),
        .wr_push_i      (wr_push_i),
        .wr_pop_i       (wr_pop_i),
        .wr_level_i     (wr_level_i),
        .reg_we_i       (reg_we_i),
        .reg_addr_i     (reg_addr_i),
        .reg_wdata_i    (reg_wdata_i),
        .reg_rdata_o    (reg_rdata_o),
        .irq_o          (irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        rx_byte_vld_i = 1'b0; rx_data_rd_i = 1'b0; rx_proto_err_i = 1'b0;
        frame_err_i = 1'b0; parity_err_i = 1'b0; tx_pop_i = 1'b0;
        wr_push_i = 1'b0; wr_pop_i = 1'b0; reg_we_i = 1'b0;
        reg_wdata_i = '0;
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [63:0] d);
        reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        @(negedge clk);
        reg_we_i = 1'b0; reg_wdata_i = '0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [63:0] d);
        reg_addr_i = a;
        #1;
        d = reg_rdata_o;
    endtask

    task automatic clear_all();
        reg_wr(2'd0, '1);
    endtask

    task automatic step();
        @(negedge clk);
        idle();
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [63:0] got;
        logic [63:0] exp;
        int thr_list [5];

        idle();
        reg_addr_i = 2'd0;
        rx_level_i = '0; tx_level_i = '0; wr_level_i = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12: reset values
        reg_rd(2'd0, got); check("R12", "status after reset", got, 64'h0);
        reg_rd(2'd1, got); check("R12", "mask after reset", got, ALL_IMPL);
        reg_rd(2'd2, got); check("R12", "almost-full thr after reset", got, 64'h100);
        reg_rd(2'd3, got); check("R12", "almost-empty thr after reset", got, 64'h0);
        check("R12", "irq after reset", 64'(irq_o), 64'h0);

        // R1: error strobes, one at a time then together
        frame_err_i = 1'b1; step();
        reg_rd(2'd0, got); check("R1", "frame", got, 64'h1 << B_FRAME);
        clear_all();
        parity_err_i = 1'b1; step();
        reg_rd(2'd0, got); check("R1", "parity", got, 64'h1 << B_PARITY);
        clear_all();
        rx_proto_err_i = 1'b1; step();
        reg_rd(2'd0, got); check("R1", "proto read", got, 64'h1 << B_PROTO);
        frame_err_i = 1'b1; parity_err_i = 1'b1; step();
        step();
        reg_rd(2'd0, got); check("R1", "sticky combined", got, 64'h40C);

        // R2: write-one-to-clear, zero writes ignored
        reg_wr(2'd0, 64'h0);
        reg_rd(2'd0, got); check("R2", "zero write", got, 64'h40C);
        reg_wr(2'd0, 64'h1 << B_PARITY);
        reg_rd(2'd0, got); check("R2", "clear parity", got, 64'h404);
        reg_wr(2'd0, 64'hFFFF_FFFF_FFFF_F000);
        reg_rd(2'd0, got); check("R2", "upper-only write", got, 64'h404);
        reg_wr(2'd0, 64'h1 << B_PROTO);
        reg_rd(2'd0, got); check("R2", "clear proto", got, 64'h004);

        // R3: event and clear of the same bit collide
        parity_err_i = 1'b1; step();
        frame_err_i = 1'b1;
        reg_we_i = 1'b1; reg_addr_i = 2'd0; reg_wdata_i = 64'h00C;
        step();
        reg_rd(2'd0, got); check("R3", "set beats clear", got, 64'h004);
        clear_all();

        // R4, R5: receive arrival across every count and several thresholds
        thr_list = '{0, 1, 100, 255, 256};
        for (int ti = 0; ti < 5; ti++) begin
            reg_wr(2'd2, 64'(thr_list[ti]));
            for (int lvl = 0; lvl <= 256; lvl++) begin
                clear_all();
                rx_level_i = LVL_W'(lvl);
                rx_byte_vld_i = 1'b1;
                step();
                reg_rd(2'd0, got);
                if (lvl >= 256) exp = 64'h1 << B_OVF;
                else exp = (64'h1 << B_RX_PUSH) | ((lvl >= thr_list[ti]) ? (64'h1 << B_AFULL) : 64'h0);
                check("R4,R5", $sformatf("rx arrive lvl=%0d thr=%0d", lvl, thr_list[ti]), got, exp);
            end
        end

        // R6, R7: transmit pop across every count and several thresholds
        thr_list = '{0, 1, 7, 128, 256};
        for (int ti = 0; ti < 5; ti++) begin
            reg_wr(2'd3, 64'(thr_list[ti]));
            for (int lvl = 0; lvl <= 256; lvl++) begin
                clear_all();
                tx_level_i = LVL_W'(lvl);
                tx_pop_i = 1'b1;
                step();
                reg_rd(2'd0, got);
                if (lvl == 0) exp = 64'h0;
                else exp = (64'h1 << B_TX_POP) | (((lvl - 1) <= thr_list[ti]) ? (64'h1 << B_AEMPTY) : 64'h0);
                check("R6,R7", $sformatf("tx pop lvl=%0d thr=%0d", lvl, thr_list[ti]), got, exp);
            end
        end

        // R8: write FIFO push and pop at every count
        for (int lvl = 0; lvl <= 4; lvl++) begin
            clear_all();
            wr_level_i = 3'(lvl); wr_push_i = 1'b1; step();
            reg_rd(2'd0, got);
            check("R8", $sformatf("wr push lvl=%0d", lvl), got, (lvl == 4) ? (64'h1 << B_WR_FULL) : 64'h0);
            clear_all();
            wr_level_i = 3'(lvl); wr_pop_i = 1'b1; step();
            reg_rd(2'd0, got);
            check("R8", $sformatf("wr pop lvl=%0d", lvl), got, (lvl > 0) ? (64'h1 << B_WR_POP) : 64'h0);
        end

        // R9: receive-data read at every count
        for (int lvl = 0; lvl <= 256; lvl++) begin
            clear_all();
            rx_level_i = LVL_W'(lvl); rx_data_rd_i = 1'b1; step();
            reg_rd(2'd0, got);
            check("R9", $sformatf("rx read lvl=%0d", lvl), got, (lvl == 0) ? (64'h1 << B_RD_EMPTY) : 64'h0);
        end

        // Fill every implemented status bit (thresholds 0)
        clear_all();
        reg_wr(2'd2, 64'h0);
        reg_wr(2'd3, 64'h0);
        rx_level_i = '0; rx_byte_vld_i = 1'b1; rx_data_rd_i = 1'b1;
        frame_err_i = 1'b1; parity_err_i = 1'b1; rx_proto_err_i = 1'b1;
        tx_level_i = 9'd1; tx_pop_i = 1'b1;
        wr_level_i = 3'd4; wr_push_i = 1'b1; wr_pop_i = 1'b1;
        step();
        rx_level_i = 9'd256; rx_byte_vld_i = 1'b1;
        step();
        reg_rd(2'd0, got); check("R1", "all events recorded", got, ALL_IMPL);

        // R10, R11: exhaustive mask sweep over a full status
        for (int m = 0; m < 4096; m++) begin
            reg_wr(2'd1, 64'(m));
            reg_rd(2'd1, got);
            check("R11", $sformatf("mask readback m=0x%0h", m), got, 64'(m) & ALL_IMPL);
            check("R10", $sformatf("irq m=0x%0h", m), 64'(irq_o),
                  ((ALL_IMPL & ~64'(m)) != 0) ? 64'h1 : 64'h0);
        end
        reg_wr(2'd1, '1);
        reg_rd(2'd1, got); check("R11", "mask all-ones write", got, ALL_IMPL);
        reg_rd(2'd0, got); check("R10", "masked events still recorded", got, ALL_IMPL);
        check("R10", "irq fully masked", 64'(irq_o), 64'h0);

        // R10: falling edge timing
        reg_wr(2'd1, ALL_IMPL & ~(64'h1 << B_FRAME));
        check("R10", "irq with frame unmasked", 64'(irq_o), 64'h1);
        reg_we_i = 1'b1; reg_addr_i = 2'd0; reg_wdata_i = 64'h1 << B_FRAME;
        #1;
        check("R10", "irq before clearing edge", 64'(irq_o), 64'h1);
        step();
        check("R10", "irq after clearing edge", 64'(irq_o), 64'h0);

        // R10: rising edge timing
        clear_all();
        reg_wr(2'd1, 64'h0);
        parity_err_i = 1'b1;
        #1;
        check("R10", "irq before event edge", 64'(irq_o), 64'h0);
        step();
        check("R10", "irq after event edge", 64'(irq_o), 64'h1);

        // R11: thresholds keep 9 bits
        reg_wr(2'd2, '1);
        reg_rd(2'd2, got); check("R11", "almost-full thr width", got, 64'h1FF);
        reg_wr(2'd3, '1);
        reg_rd(2'd3, got); check("R11", "almost-empty thr width", got, 64'h1FF);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule